// File: doc/BRIEF.md
# Addressed Serial Slave Front End with Pause Control

This block is the serial side of a small peripheral that shares a four-wire serial bus with up to three identical neighbours, for example a bank of digitally set resistor wiper registers. It runs entirely on a fast system clock. The serial clock, select, pause, data and protect inputs are brought into that domain through a synchronizer, and edges are then found on the synchronized serial clock. Received bytes are handed to a register decoder one at a time. Read data from that decoder is shifted back out.

Each transaction starts when select falls. The first byte carries a fixed six-bit device-type code followed by a two-bit device number, and that number must equal the two strap pins. If the byte matches, every later byte is passed to the decoder with a one-cycle strobe, and the serial output is enabled. If it does not match, the block stays silent until select is released. The pause input lets the bus master freeze a transfer in the middle of a byte and pick it up again later. A protect input masks the decoder's requests to start a nonvolatile write.

Top module: `spi_hold_slave`

## Requirements
- R1: After reset, no byte is accepted and the output stays disabled until `cs_n` has been seen going from 1 to 0.
- R2: While `cs_n` is 1, `so_oe` is 0. Raising `cs_n` in the middle of a byte discards the partial bits, and the next transaction starts again at bit 7 of its address byte.
- R3: The address byte is compared as {DEV_CODE[5:0], strap[1:0]}, where bit 7 is the first bit received. On a mismatch no `rx_valid` is produced and `so_oe` stays 0 until `cs_n` next rises.
- R4: After a matching address, each group of eight `sck` rising edges produces one byte on `rx_data`, built MSB first from `si`, together with `rx_valid`. `rx_first` is 1 only for the first such byte of the transaction.
- R5: `so_oe` is 1 only after a matching address while `cs_n` is 0, and it is 0 during the address byte itself. `tx_byte` is captured when a byte completes, including the address byte, and is sent MSB first. One bit changes `so` on each falling edge of `sck`, so the master reads it on the next rising edge.
- R6: If `hold_n` goes to 0 while `sck` is 0, the transfer is paused and `sck` edges are ignored. When `hold_n` returns to 1 while `sck` is 0, the transfer continues at the same bit and byte position.
- R7: If `hold_n` changes while `sck` is 1, the change takes effect only when `sck` next goes to 0. The falling edge at that point is still processed.
- R8: `nvw_go` is the registered value of `nvw_req` AND `wp_n`, so it is 0 whenever `wp_n` is 0.
- R9: `rx_valid` is high for exactly one system clock cycle per byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sck | input | 1 | Serial clock from the bus master |
| cs_n | input | 1 | Select, active low |
| hold_n | input | 1 | Pause request, active low |
| si | input | 1 | Serial data in |
| strap | input | 2 | Device number straps |
| wp_n | input | 1 | Write protect, active low |
| tx_byte | input | 8 | Next byte to send, from the register decoder |
| nvw_req | input | 1 | Nonvolatile write request from the register decoder |
| so | output | 1 | Serial data out (valid when `so_oe` is 1) |
| so_oe | output | 1 | Output enable for the serial data pad |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| rx_first | output | 1 | Marks the first byte after the address |
| nvw_go | output | 1 | Write request after the protect gate |

## Verification
The assertions check these properties on every cycle:
- The output enable drops one cycle after select is released.
- The strobe never lasts two cycles, and it only comes from the matched state.
- A mismatched transaction stays silent.
- No strobe appears while the pause is active.
- The pause flag only changes while the serial clock is low.
- Protect low always masks the write request.
- The idle state is left only on a select fall.

Only the bench's scenarios show the rest, by checking against a behavioural model:
- that bits are assembled MSB first;
- the exact bit sequence on the serial output;
- that a transfer resumes at the correct bit after a pause started in either clock phase;
- that a partial byte is dropped when select rises;
- the strap-dependent address match.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_LIVE = 2'd2,
    PH_DEAF = 2'd3
  } phase_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_edge_ctl.sv
module spi_edge_ctl (
  input  logic clk,
  input  logic rst,
  input  logic sck_s,
  input  logic cs_n_s,
  input  logic hold_n_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic sel_drop,
  output logic paused
);
  logic sck_q;
  logic cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b0;
      paused <= 1'b0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_n_s;
      // the pause flag follows the pin only in the clock-low phase
      if (!sck_s) paused <= !hold_n_s;
    end
  end

  assign sck_rise = sck_s & ~sck_q & ~paused;
  assign sck_fall = ~sck_s & sck_q & ~paused;
  assign cs_fall  = cs_q & ~cs_n_s;
  assign sel_drop = cs_n_s;

  AST_PAUSE_LOW_PHASE: assert property (@(posedge clk) disable iff (rst)
    (paused != $past(paused)) |-> !$past(sck_s)); // R7
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
  import spi_hold_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int ADDR_W   = 2,
  parameter logic [BYTE_W-ADDR_W-1:0] DEV_CODE = 6'b101000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              cs_fall,
  input  logic              sel_drop,
  input  logic              si_s,
  input  logic [ADDR_W-1:0] strap,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_first,
  output logic              so,
  output logic              so_oe
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  phase_e            ph;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [CNT_W-1:0]  bitcnt;
  logic              first_pend;
  logic [BYTE_W-1:0] rx_next;
  logic              last;
  logic              shifting;

  assign rx_next  = {rx_sh[BYTE_W-2:0], si_s};
  assign last     = (bitcnt == LAST_BIT);
  assign shifting = (ph == PH_ADDR) || (ph == PH_LIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= PH_IDLE;
      rx_sh      <= '0;
      tx_sh      <= '0;
      bitcnt     <= '0;
      first_pend <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      rx_first   <= 1'b0;
      so         <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (sel_drop) begin
        ph     <= PH_IDLE;
        bitcnt <= '0;
      end else if (cs_fall) begin
        ph     <= PH_ADDR;
        bitcnt <= '0;
      end else if (shifting) begin
        if (sck_rise) begin
          rx_sh  <= rx_next;
          bitcnt <= last ? '0 : bitcnt + CNT_W'(1);
          if (last) begin
            if (ph == PH_ADDR) begin
              if (rx_next == {DEV_CODE, strap}) begin
                ph         <= PH_LIVE;
                tx_sh      <= tx_byte;
                first_pend <= 1'b1;
              end else begin
                ph <= PH_DEAF;
              end
            end else begin
              rx_data    <= rx_next;
              rx_valid   <= 1'b1;
              rx_first   <= first_pend;
              first_pend <= 1'b0;
              tx_sh      <= tx_byte;
            end
          end
        end else if (sck_fall && ph == PH_LIVE) begin
          so    <= tx_sh[BYTE_W-1];
          tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign so_oe = (ph == PH_LIVE);

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R9
  AST_STROBE_FROM_LIVE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ($past(ph) == PH_LIVE)); // R3
  AST_DEAF_STAYS: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_DEAF && !sel_drop) |=> (ph == PH_DEAF)); // R3
  AST_OE_DROPS: assert property (@(posedge clk) disable iff (rst)
    sel_drop |=> !so_oe); // R2
  AST_START_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_IDLE && !cs_fall) |=> (ph == PH_IDLE)); // R1
endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave #(
  parameter int BYTE_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [BYTE_W-ADDR_W-1:0] DEV_CODE = 6'b101000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              hold_n,
  input  logic              si,
  input  logic [ADDR_W-1:0] strap,
  input  logic              wp_n,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              nvw_req,
  output logic              so,
  output logic              so_oe,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_first,
  output logic              nvw_go
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0] pins_s;
  logic sck_s, cs_n_s, hold_n_s, si_s, wp_s;
  logic sck_rise, sck_fall, cs_fall, sel_drop, paused;

  spi_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sck, cs_n, hold_n, si, wp_n}),
    .q   (pins_s)
  );

  assign {sck_s, cs_n_s, hold_n_s, si_s, wp_s} = pins_s;

  spi_edge_ctl u_edge (
    .clk      (clk),
    .rst      (rst),
    .sck_s    (sck_s),
    .cs_n_s   (cs_n_s),
    .hold_n_s (hold_n_s),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_fall  (cs_fall),
    .sel_drop (sel_drop),
    .paused   (paused)
  );

  spi_byte_engine #(
    .BYTE_W   (BYTE_W),
    .ADDR_W   (ADDR_W),
    .DEV_CODE (DEV_CODE)
  ) u_eng (
    .clk      (clk),
    .rst      (rst),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_fall  (cs_fall),
    .sel_drop (sel_drop),
    .si_s     (si_s),
    .strap    (strap),
    .tx_byte  (tx_byte),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_first (rx_first),
    .so       (so),
    .so_oe    (so_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) nvw_go <= 1'b0;
    else     nvw_go <= nvw_req & wp_s;
  end

  AST_PROTECT_MASKS: assert property (@(posedge clk) disable iff (rst)
    !wp_s |=> !nvw_go); // R8
  AST_PAUSE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    paused |=> !rx_valid); // R6
endmodule

// File: tb/spi_hold_slave_test.sv
module spi_hold_slave_test;
  localparam logic [5:0] DEV = 6'b101000;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst, sck, cs_n, hold_n, si, wp_n, nvw_req;
  logic [1:0] strap;
  logic [7:0] tx_byte;
  logic so, so_oe, rx_valid, rx_first, nvw_go;
  logic [7:0] rx_data;

  int checks = 0;
  int failures = 0;
  logic [8:0] exp_q[$];
  logic prev_valid = 1'b0;

  always #5 clk = ~clk;

  spi_hold_slave #(.DEV_CODE(DEV)) uut (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .hold_n(hold_n), .si(si),
    .strap(strap), .wp_n(wp_n), .tx_byte(tx_byte), .nvw_req(nvw_req),
    .so(so), .so_oe(so_oe), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_first(rx_first), .nvw_go(nvw_go)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model of received bytes: compared every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        check(!prev_valid, "R9 strobe width", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected byte", {rx_first, rx_data}, 0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check({rx_first, rx_data} == e, "R4 byte/first", {rx_first, rx_data}, e);
        end
      end
      prev_valid = rx_valid;
    end
  end

  task automatic pulses();
    repeat (2) begin
      si = ~si; sck = 1'b1; tick(H); sck = 1'b0; tick(H);
    end
  endtask

  // mode 0: no output check, 1: expect so_oe low, 2: expect so bits
  task automatic send_byte(input logic [7:0] b, input int nbits, input int mode,
                           input string tag, input logic [7:0] exp_so,
                           input int hold_at, input int hold_kind);
    for (int i = 7; i >= 8 - nbits; i--) begin
      si = b[i];
      tick(H);
      if (mode == 1) check(so_oe == 1'b0, tag, so_oe, 0);
      if (mode == 2) begin
        check(so_oe == 1'b1, "R5 oe in live", so_oe, 1);
        check(so == exp_so[i], tag, so, exp_so[i]);
      end
      if (hold_at == i && hold_kind == 1) begin
        sck = 1'b1; tick(2); hold_n = 1'b0; tick(H - 2);
        sck = 1'b0; tick(H);
        pulses();
        hold_n = 1'b1; tick(2);
      end else begin
        sck = 1'b1; tick(H); sck = 1'b0;
        if (hold_at == i && hold_kind == 0) begin
          tick(2); hold_n = 1'b0; tick(H);
          pulses();
          hold_n = 1'b1; tick(2);
        end
      end
    end
  endtask

  task automatic select();
    cs_n = 1'b0; tick(H);
  endtask

  task automatic release_cs();
    cs_n = 1'b1; tick(10);
    check(so_oe == 1'b0, "R2 oe off when deselected", so_oe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; sck = 1'b0; cs_n = 1'b0; hold_n = 1'b1; si = 1'b0;
    wp_n = 1'b1; nvw_req = 1'b0; strap = 2'b01; tx_byte = 8'h00;
    tick(5); rst = 1'b0; tick(3);
    check(so_oe == 1'b0, "reset so_oe", so_oe, 0);
    check(rx_valid == 1'b0, "reset rx_valid", rx_valid, 0);
    check(nvw_go == 1'b0, "reset nvw_go", nvw_go, 0);

    // R1: select already low since reset, no fall seen
    send_byte({DEV, 2'b01}, 8, 1, "R1 no start without fall", 8'h00, -1, 0);
    send_byte(8'h77, 8, 1, "R1 still silent", 8'h00, -1, 0);
    release_cs();

    // R4/R5: normal transaction
    tx_byte = 8'hC3;
    select();
    send_byte({DEV, 2'b01}, 8, 1, "R5 oe low in address", 8'h00, -1, 0);
    tx_byte = 8'h96;
    exp_q.push_back({1'b1, 8'h5A});
    send_byte(8'h5A, 8, 2, "R5 so bit", 8'hC3, -1, 0);
    exp_q.push_back({1'b0, 8'hE1});
    send_byte(8'hE1, 8, 2, "R5 so bit", 8'h96, -1, 0);
    release_cs();

    // R6/R7: pauses with other strap value
    strap = 2'b10; tx_byte = 8'h5B;
    select();
    send_byte({DEV, 2'b10}, 8, 1, "R5 oe low in address", 8'h00, -1, 0);
    exp_q.push_back({1'b1, 8'h3C});
    send_byte(8'h3C, 8, 2, "R6 so after pause", 8'h5B, 4, 0);
    exp_q.push_back({1'b0, 8'hA7});
    send_byte(8'hA7, 8, 2, "R7 so after pause", 8'h5B, 2, 1);
    release_cs();

    // R3: strap number mismatch
    select();
    send_byte({DEV, 2'b01}, 8, 1, "R3 address phase", 8'h00, -1, 0);
    send_byte(8'h12, 8, 1, "R3 ignored after mismatch", 8'h00, -1, 0);
    send_byte(8'h34, 8, 1, "R3 ignored after mismatch", 8'h00, -1, 0);
    release_cs();

    // R3: device code mismatch
    select();
    send_byte({6'b101001, 2'b10}, 8, 1, "R3 address phase", 8'h00, -1, 0);
    send_byte(8'h56, 8, 1, "R3 ignored after code mismatch", 8'h00, -1, 0);
    release_cs();

    // R2: select rises mid-byte, partial bits dropped
    tx_byte = 8'h81;
    select();
    send_byte({DEV, 2'b10}, 8, 0, "", 8'h00, -1, 0);
    exp_q.push_back({1'b1, 8'h11});
    send_byte(8'h11, 8, 2, "R5 so bit", 8'h81, -1, 0);
    send_byte(8'hFF, 3, 0, "", 8'h00, -1, 0);
    release_cs();
    select();
    send_byte({DEV, 2'b10}, 3, 0, "", 8'h00, -1, 0);
    release_cs();
    tx_byte = 8'h6E;
    select();
    send_byte({DEV, 2'b10}, 8, 1, "R2 fresh address", 8'h00, -1, 0);
    exp_q.push_back({1'b1, 8'h22});
    send_byte(8'h22, 8, 2, "R2 fresh byte so", 8'h6E, -1, 0);
    release_cs();

    // R8: write protect
    nvw_req = 1'b1; wp_n = 1'b0; tick(6);
    check(nvw_go == 1'b0, "R8 protect blocks", nvw_go, 0);
    wp_n = 1'b1; tick(6);
    check(nvw_go == 1'b1, "R8 request passes", nvw_go, 1);
    nvw_req = 1'b0; tick(3);
    check(nvw_go == 1'b0, "R8 request drops", nvw_go, 0);

    tick(20);
    check(exp_q.size() == 0, "R4 all bytes delivered", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule